// File: doc/BRIEF.md
# Carrier Presence Qualifier with Hysteresis

This block decides whether a valid line carrier is present. It takes a stream of received-level estimates, each marked by a one-cycle strobe. A two-threshold comparator gives the decision hysteresis: a higher threshold starts a detection and a lower one ends it. The defaults are set about 3 dB apart, near -44 dBm and -47 dBm. Every strobe that the comparator accepts retriggers a one-shot. The one-shot fills short gaps between detections, so an isolated missing sample does not count as loss of carrier.

A four-state machine times how long the one-shot stays active or idle. Time is counted in millisecond ticks. Before it asserts the active-low carrier-detect output, the carrier must persist for a programmable turn-on delay (default about 640 ms). Before it releases that output, the carrier must stay absent for a separate turn-off delay (default about 54 ms). The demodulated data bit passes to the output only while carrier is detected. At all other times the data output is held high (mark). Power-down drops detection at once.

The states are IDLE (no carrier, timer clear), ARMING (carrier seen, turn-on timer running), LOCKED (carrier detected) and RELEASING (carrier lost, turn-off timer running). The transitions are:
- IDLE to ARMING when the one-shot becomes active.
- ARMING to IDLE when the one-shot drops.
- ARMING to LOCKED when the timer reaches the turn-on delay.
- LOCKED to RELEASING when the one-shot drops.
- RELEASING to LOCKED when the one-shot is active again.
- RELEASING to IDLE when the timer reaches the turn-off delay.

Every state change clears the timer. Reset and power-down force IDLE from any state.

Top module: `cd_qualifier`

## Requirements
- R1: After reset, `cd_n` is 1 and `rxd` is 1, whatever the value of `rxd_raw`.
- R2: While carrier is not detected, a strobed sample counts as a hit only if it is greater than or equal to `thr_on`. Once a hit has been taken, later samples greater than or equal to `thr_off` also count as hits. A sample below `thr_off` ends the hit condition.
- R3: Each hit holds the one-shot active for HOLD_TICKS ticks. Hits spaced closer than that keep it active without a break. Hits spaced wider let it lapse, and qualification starts over.
- R4: `cd_n` falls only after the one-shot has stayed active without a break for `dly_on` ticks. One tick is CLK_PER_TICK clock cycles.
- R5: Once `cd_n` is low, it rises only after the one-shot has stayed inactive without a break for `dly_off` ticks.
- R6: If the one-shot drops during the turn-on wait, that timer restarts from zero at the next activation.
- R7: If the one-shot drops out while carrier is detected and recovers before `dly_off` ticks pass, `cd_n` stays low the whole time.
- R8: `rxd` equals `rxd_raw` while `cd_n` is 0 and is 1 while `cd_n` is 1.
- R9: While `pwr_down` is 1, `cd_n` is 1 from the next cycle, strobes cause no detection, and the hysteresis state, one-shot and timers clear. After `pwr_down` returns to 0, a full `dly_on` is needed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Disables detection and clears all state |
| lvl_strobe | input | 1 | One-cycle strobe marking a valid level sample |
| lvl_sample | input | LVL_W | Received-level estimate |
| thr_on | input | LVL_W | Threshold that starts a detection |
| thr_off | input | LVL_W | Threshold that sustains a detection |
| dly_on | input | DLY_W | Turn-on qualification delay in ticks |
| dly_off | input | DLY_W | Turn-off qualification delay in ticks |
| rxd_raw | input | 1 | Demodulated data bit |
| cd_n | output | 1 | Carrier detect, active low |
| rxd | output | 1 | Gated receive data, 1 when no carrier |

## Verification
The checker relies on four assumptions about the inputs:
- `thr_on` is not below `thr_off`.
- CLK_PER_TICK is at least 2, so ticks never fall on adjacent cycles.
- `lvl_strobe` is a single-cycle pulse.
- The thresholds and delays stay constant while detection is running.

The bench sets the thresholds once with `thr_on` above `thr_off` and never changes them. It always drops each strobe on the next falling edge. It sizes every strobe gap and sampling point from the tick and hold parameters, with one tick of margin on each side, because ticks are free-running.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
    typedef enum logic [1:0] {
        CD_IDLE      = 2'd0,
        CD_ARMING    = 2'd1,
        CD_LOCKED    = 2'd2,
        CD_RELEASING = 2'd3
    } cd_state_e;
endpackage

// File: rtl/cdq_tick_gen.sv
module cdq_tick_gen #(
    parameter int unsigned DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (div_cnt == LAST) begin
            div_cnt <= '0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            tick    <= 1'b0;
        end
    end
endmodule

// File: rtl/cdq_hyst_cmp.sv
module cdq_hyst_cmp #(
    parameter int unsigned LVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             strobe,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] on_thr,
    input  logic [LVL_W-1:0] off_thr,
    output logic             hit
);
    logic above;
    logic above_nxt;

    // Threshold in use depends on the remembered side of the hysteresis band.
    always_comb begin
        above_nxt = above ? (level >= off_thr) : (level >= on_thr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            above <= 1'b0;
            hit   <= 1'b0;
        end else begin
            hit <= strobe && above_nxt;
            if (strobe) begin
                above <= above_nxt;
            end
        end
    end
endmodule

// File: rtl/cdq_oneshot.sv
module cdq_oneshot #(
    parameter int unsigned SPAN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic trig,
    input  logic tick,
    output logic active
);
    localparam int unsigned SW = $clog2(SPAN + 1);

    logic [SW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            remain <= '0;
        end else if (trig) begin
            remain <= SW'(SPAN);
        end else if (tick && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign active = (remain != '0);
endmodule

// File: rtl/cd_qualifier.sv
module cd_qualifier
    import cdq_pkg::*;
#(
    parameter int unsigned LVL_W        = 16,
    parameter int unsigned DLY_W        = 12,
    parameter int unsigned CLK_PER_TICK = 50000,
    parameter int unsigned HOLD_TICKS   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             lvl_strobe,
    input  logic [LVL_W-1:0] lvl_sample,
    input  logic [LVL_W-1:0] thr_on,
    input  logic [LVL_W-1:0] thr_off,
    input  logic [DLY_W-1:0] dly_on,
    input  logic [DLY_W-1:0] dly_off,
    input  logic             rxd_raw,
    output logic             cd_n,
    output logic             rxd
);
    localparam logic [DLY_W-1:0] CNT_MAX = {DLY_W{1'b1}};

    logic             ms_tick;
    logic             cmp_hit;
    logic             os_active;
    logic [DLY_W-1:0] qual_cnt;
    logic             qual_done;
    cd_state_e        state, state_nxt;

    cdq_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwr_down),
        .tick  (ms_tick)
    );

    cdq_hyst_cmp #(.LVL_W(LVL_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pwr_down),
        .strobe  (lvl_strobe),
        .level   (lvl_sample),
        .on_thr  (thr_on),
        .off_thr (thr_off),
        .hit     (cmp_hit)
    );

    cdq_oneshot #(.SPAN(HOLD_TICKS)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pwr_down),
        .trig   (cmp_hit),
        .tick   (ms_tick),
        .active (os_active)
    );

    always_comb begin
        qual_done = (state == CD_ARMING) ? (qual_cnt >= dly_on)
                                         : (qual_cnt >= dly_off);
    end

    // Next-state selection.
    always_comb begin
        state_nxt = state;
        unique case (state)
            CD_IDLE:      if (os_active) state_nxt = CD_ARMING;
            CD_ARMING:    if (!os_active) state_nxt = CD_IDLE;
                          else if (qual_done) state_nxt = CD_LOCKED;
            CD_LOCKED:    if (!os_active) state_nxt = CD_RELEASING;
            CD_RELEASING: if (os_active) state_nxt = CD_LOCKED;
                          else if (qual_done) state_nxt = CD_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            state <= CD_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Qualification timer: restarts on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down || (state_nxt != state)) begin
            qual_cnt <= '0;
        end else if (ms_tick && qual_cnt != CNT_MAX) begin
            qual_cnt <= qual_cnt + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state)
            CD_IDLE, CD_ARMING:        cd_n = 1'b1;
            CD_LOCKED, CD_RELEASING:   cd_n = 1'b0;
        endcase
        rxd = cd_n | rxd_raw;
    end
endmodule

// File: rtl/cdq_checker.sv
module cdq_checker #(
    parameter int unsigned LVL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_down,
    input logic             lvl_strobe,
    input logic [LVL_W-1:0] lvl_sample,
    input logic [LVL_W-1:0] thr_on,
    input logic             cd_n,
    input logic             present,
    input logic             tick
);
    p_pd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> cd_n);

    p_lock_needs_carrier_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cd_n) |-> ($past(present) && !$past(pwr_down)));

    p_release_needs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cd_n) && !$past(pwr_down)) |-> !$past(present));

    p_hit_arms_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
        (lvl_strobe && lvl_sample >= thr_on) |=> ##1 present);

    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

bind cd_qualifier cdq_checker #(.LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .lvl_strobe (lvl_strobe),
    .lvl_sample (lvl_sample),
    .thr_on     (thr_on),
    .cd_n       (cd_n),
    .present    (os_active),
    .tick       (ms_tick)
);

// File: tb/cd_qualifier_tb_top.sv
module cd_qualifier_tb_top;
    localparam int LVL_W = 16;
    localparam int DLY_W = 12;
    localparam logic [LVL_W-1:0] STRONG = 16'd800;
    localparam logic [LVL_W-1:0] MID    = 16'd420;
    localparam logic [LVL_W-1:0] WEAK   = 16'd100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_down = 1'b0;
    logic             lvl_strobe = 1'b0;
    logic [LVL_W-1:0] lvl_sample = '0;
    logic [LVL_W-1:0] thr_on = 16'd490;
    logic [LVL_W-1:0] thr_off = 16'd350;
    logic [DLY_W-1:0] dly_on = 12'd8;
    logic [DLY_W-1:0] dly_off = 12'd3;
    logic             rxd_raw = 1'b0;
    logic             cd_n;
    logic             rxd;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit saw_high = 1'b0;
    bit saw_low = 1'b0;

    always #10 clk = ~clk;

    cd_qualifier #(
        .LVL_W(LVL_W), .DLY_W(DLY_W), .CLK_PER_TICK(10), .HOLD_TICKS(4)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .lvl_strobe(lvl_strobe), .lvl_sample(lvl_sample),
        .thr_on(thr_on), .thr_off(thr_off),
        .dly_on(dly_on), .dly_off(dly_off),
        .rxd_raw(rxd_raw), .cd_n(cd_n), .rxd(rxd)
    );

    always @(negedge clk) begin
        if (mon_en) begin
            if (cd_n) saw_high = 1'b1;
            else      saw_low  = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [LVL_W-1:0] lvl, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            lvl_sample = lvl;
            lvl_strobe = 1'b1;
            @(negedge clk);
            lvl_strobe = 1'b0;
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic mon_start();
        saw_high = 1'b0;
        saw_low  = 1'b0;
        mon_en   = 1'b1;
    endtask

    task automatic settle();
        mon_en = 1'b0;
        repeat (150) @(negedge clk);
    endtask

    // Acquire from idle: high at 68 cycles after first strobe, low by 128.
    task automatic acquire(input string req);
        send(STRONG, 3, 20);
        repeat (8) @(negedge clk);
        check(cd_n == 1'b1, req, "cd_n before turn-on delay", cd_n, 1);
        send(STRONG, 3, 20);
        check(cd_n == 1'b0, req, "cd_n after turn-on delay", cd_n, 0);
    endtask

    task automatic t_reset();
        rxd_raw = 1'b0;
        check(cd_n == 1'b1, "R1", "cd_n after reset", cd_n, 1);
        check(rxd == 1'b1, "R1", "rxd after reset", rxd, 1);
    endtask

    task automatic t_mid_no_start();
        mon_start();
        send(MID, 12, 20);
        check(saw_low == 1'b0, "R2", "detect from level below thr_on", saw_low, 0);
        settle();
    endtask

    task automatic t_acquire_and_gate();
        acquire("R4");
        rxd_raw = 1'b0;
        #1 check(rxd == 1'b0, "R8", "rxd passes 0 while locked", rxd, 0);
        rxd_raw = 1'b1;
        #1 check(rxd == 1'b1, "R8", "rxd passes 1 while locked", rxd, 1);
        rxd_raw = 1'b0;
    endtask

    task automatic t_hold_mid();
        mon_start();
        send(MID, 10, 20);
        check(saw_high == 1'b0, "R2", "mid level holds detection", saw_high, 0);
    endtask

    task automatic t_dropout();
        mon_start();
        repeat (20) @(negedge clk);
        send(STRONG, 3, 20);
        check(saw_high == 1'b0, "R7", "short dropout keeps cd_n low", saw_high, 0);
    endtask

    task automatic t_release();
        mon_en = 1'b0;
        send(WEAK, 2, 20);
        repeat (5) @(negedge clk);
        check(cd_n == 1'b0, "R5", "cd_n before turn-off delay", cd_n, 0);
        repeat (60) @(negedge clk);
        check(cd_n == 1'b1, "R5", "cd_n after weak samples", cd_n, 1);
        rxd_raw = 1'b0;
        #1 check(rxd == 1'b1, "R8", "rxd forced high without carrier", rxd, 1);
        settle();
    endtask

    task automatic t_restart();
        send(STRONG, 3, 20);
        repeat (50) @(negedge clk);
        check(cd_n == 1'b1, "R6", "cd_n after interrupted arming", cd_n, 1);
        acquire("R6");
        send(WEAK, 2, 20);
        settle();
    endtask

    task automatic t_sparse();
        mon_start();
        send(STRONG, 7, 60);
        check(saw_low == 1'b0, "R3", "widely spaced hits never qualify", saw_low, 0);
        settle();
    endtask

    task automatic t_powerdown();
        acquire("R9");
        pwr_down = 1'b1;
        @(negedge clk);
        check(cd_n == 1'b1, "R9", "cd_n one cycle into power-down", cd_n, 1);
        check(rxd == 1'b1, "R9", "rxd during power-down", rxd, 1);
        mon_start();
        send(STRONG, 8, 20);
        check(saw_low == 1'b0, "R9", "no detection while powered down", saw_low, 0);
        mon_en = 1'b0;
        pwr_down = 1'b0;
        @(negedge clk);
        acquire("R9");
        send(WEAK, 2, 20);
        settle();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_mid_no_start();
        t_acquire_and_gate();
        t_hold_mid();
        t_dropout();
        t_release();
        t_restart();
        t_sparse();
        t_powerdown();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule